// File: doc/BRIEF.md
# Card Controller Status Flag Register

This block holds the 32-bit status word of a card-interface controller. Two kinds of flag share the word. Event flags latch a one-cycle pulse from the command or data engines and hold it until software writes a one to the matching bit of a separate clear register. Level flags show the present state of the engines on every cycle and cannot be cleared.

One of the event flags comes from a timer inside the block. The timer starts when a command that expects a response goes out. If no response arrives within 64 interface clocks, it raises the response-timeout flag.

A mask register selects the status bits that drive a single interrupt line. Software reaches the block through a plain strobe interface: a two-bit address, a write enable, write data and combinational read data.

Top module: `card_status_regs`

## Requirements
- R1: After reset every event flag and the mask register read zero, and the interrupt output is low while the level inputs are zero.
- R2: The event flags sit at bits 0, 1, 3 to 10, 22 and 23 (mask 0x00C007FF, with bit 2 set by the timer). A pulse on evtIn at one of these positions sets the bit on the next edge, and the bit stays set with no further pulse.
- R3: A write to address 1 clears every event flag whose wrData bit is 1. Flags whose wrData bit is 0 keep their value.
- R4: When an event pulse and a clear for the same bit fall in the same cycle, the bit ends up set.
- R5: Bits 21:11 of the status word equal liveIn[10:0] in the same cycle, and writes to the clear register do not change them.
- R6: Bits 31:24 read zero. A pulse on evtIn at bits 11 to 21 or 24 to 31 does not change the status word.
- R7: Bit 2 sets exactly 64 clock edges after the edge that samples cmdIssued if respSeen is not sampled in between. A pulse on evtIn[2] does not change bit 2.
- R8: A respSeen sampled on any of those 64 edges cancels the timeout. A new cmdIssued restarts the 64-edge count.
- R9: A write to address 0 changes neither the status word nor the mask.
- R10: Address 2 is a read/write mask register. irq is high whenever any status bit, event or level, is 1 at a position where the mask is 1.
- R11: Address 1 and address 3 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | 32 | One-cycle event pulses, bit-aligned to the status word |
| liveIn | input | 11 | Level flags shown at status bits 21:11 |
| cmdIssued | input | 1 | Pulse: a command expecting a response was sent |
| respSeen | input | 1 | Pulse: a command response arrived |
| regAddr | input | 2 | Register select: 0 status, 1 clear, 2 mask |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the selected register |
| irq | output | 1 | OR of status bits under the mask |

## Verification
On every cycle the assertions check three things about the event flags: a set flag holds unless a clear is written, a clear leaves only event-set bits standing, and any event always lands. The same per-cycle checks cover the timer, which disarms after it fires or sees a response, and mask writes, which take effect on the next edge.

Some behaviours only the bench's scenarios can show. These are the exact 64-edge timeout distance, the restart of the count by a second command, the masking of non-event and reserved positions, and the interrupt built from mixed event and level bits. The bench also runs a randomized stretch against its own model of the word.

// File: rtl/cardstat_pkg.sv
`timescale 1ns/1ps
package cardstat_pkg;
  localparam int REG_W    = 32;
  localparam int LIVE_W   = 11;
  localparam int LIVE_LSB = 11;
  localparam int TMO_BIT  = 2;
  // Latched event positions: 0,1,3..10 from pulses, 2 from the timer, 22,23
  localparam logic [REG_W-1:0] STICKY_BITS = 32'h00C0_07FF;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CLEAR  = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_SPARE  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic clrStb;
    logic maskStb;
    logic tmoStb;
  } ctrlStrb_t;
endpackage

// File: rtl/cardstat_ctrl.sv
`timescale 1ns/1ps
module cardstat_ctrl
  import cardstat_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdIssued,
  input  logic      respSeen,
  input  logic [1:0] regAddr,
  input  logic      wrEn,
  output ctrlStrb_t strb
);
  localparam int CNT_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  regSel_e        sel;
  logic           armedQ;
  logic [CNT_W-1:0] cntQ;
  logic           expire;

  assign sel    = regSel_e'(regAddr);
  assign expire = armedQ && !cmdIssued && !respSeen && (cntQ == CNT_LAST);

  always_comb begin
    strb         = '0;
    strb.clrStb  = wrEn && (sel == SEL_CLEAR);
    strb.maskStb = wrEn && (sel == SEL_MASK);
    strb.tmoStb  = expire;
  end

  // Response timer: restarts on every command, disarms on response or expiry
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedQ <= 1'b0;
      cntQ   <= '0;
    end else if (cmdIssued) begin
      armedQ <= 1'b1;
      cntQ   <= '0;
    end else if (armedQ) begin
      if (respSeen || expire) begin
        armedQ <= 1'b0;
        cntQ   <= '0;
      end else begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  // R7
  tmo_disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.tmoStb |=> !armedQ);
  // R8
  resp_cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && respSeen && !cmdIssued) |=> (!armedQ && !strb.tmoStb));
  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdIssued |=> (armedQ && cntQ == '0));
endmodule

// File: rtl/cardstat_datapath.sv
`timescale 1ns/1ps
module cardstat_datapath
  import cardstat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [REG_W-1:0]  evtIn,
  input  logic [LIVE_W-1:0] liveIn,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  output logic              irq
);
  localparam logic [REG_W-1:0] TMO_ONEHOT = REG_W'(1) << TMO_BIT;

  logic [REG_W-1:0] stickyQ, stickyD;
  logic [REG_W-1:0] evtSet, clrVec;
  logic [REG_W-1:0] maskQ;
  logic [REG_W-1:0] statusVec;
  regSel_e          sel;

  assign evtSet = (evtIn & STICKY_BITS & ~TMO_ONEHOT)
                | (strb.tmoStb ? TMO_ONEHOT : '0);
  assign clrVec = strb.clrStb ? wrData : '0;

  // One latch cell per event position; other positions stay zero
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (STICKY_BITS[i]) begin : g_evt
      assign stickyD[i] = evtSet[i] | (stickyQ[i] & ~clrVec[i]);
    end else begin : g_none
      assign stickyD[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stickyQ <= '0;
      maskQ   <= '0;
    end else begin
      stickyQ <= stickyD;
      if (strb.maskStb) maskQ <= wrData;
    end
  end

  assign statusVec = stickyQ | (REG_W'(liveIn) << LIVE_LSB);
  assign sel       = regSel_e'(regAddr);

  always_comb begin
    unique case (sel)
      SEL_STATUS: rdData = statusVec;
      SEL_MASK:   rdData = maskQ;
      default:    rdData = '0;
    endcase
  end

  assign irq = |(statusVec & maskQ);

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrStb |=> ((stickyQ & $past(stickyQ)) == $past(stickyQ)));
  // R4
  event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|evtSet) |=> ((stickyQ & $past(evtSet)) == $past(evtSet)));
  // R3
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrStb |=> ((stickyQ & $past(wrData & ~evtSet)) == '0));
  // R10
  mask_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskStb |=> (maskQ == $past(wrData)));
  // R10
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.maskStb |=> $stable(maskQ));
endmodule

// File: rtl/card_status_regs.sv
`timescale 1ns/1ps
module card_status_regs
  import cardstat_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] evtIn,
  input  logic [10:0] liveIn,
  input  logic        cmdIssued,
  input  logic        respSeen,
  input  logic [1:0]  regAddr,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        irq
);
  ctrlStrb_t strb;

  cardstat_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdIssued(cmdIssued), .respSeen(respSeen),
    .regAddr(regAddr), .wrEn(wrEn), .strb(strb)
  );

  cardstat_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .evtIn(evtIn), .liveIn(liveIn),
    .regAddr(regAddr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );
endmodule

// File: tb/card_status_regs_bench.sv
`timescale 1ns/1ps
module card_status_regs_bench;
  localparam logic [31:0] EVT_POS = 32'h00C0_07FF;
  localparam logic [31:0] TMO_POS = 32'h0000_0004;
  // {doClr, evt[31:0], clr[31:0]}
  localparam logic [64:0] VEC_TBL [0:7] = '{
    {1'b0, 32'h0000_0001, 32'h0000_0000},
    {1'b0, 32'h00C0_0002, 32'h0000_0000},
    {1'b1, 32'h0000_0000, 32'h0000_0001},
    {1'b0, 32'h0000_07F8, 32'h0000_0000},
    {1'b1, 32'h0000_0010, 32'h0000_0010},
    {1'b0, 32'hFF3F_F800, 32'h0000_0000},
    {1'b0, 32'h0000_0004, 32'h0000_0000},
    {1'b1, 32'h0000_0000, 32'hFFFF_FFFF}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] evtIn = '0;
  logic [10:0] liveIn = '0;
  logic        cmdIssued = 1'b0, respSeen = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int checks = 0, errors = 0;
  logic [31:0] model = '0;
  logic [31:0] maskM = '0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  card_status_regs u_card_status_regs (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .liveIn(liveIn),
    .cmdIssued(cmdIssued), .respSeen(respSeen), .regAddr(regAddr),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  function automatic logic [31:0] expStatus();
    return (model & EVT_POS) | ({21'b0, liveIn} << 11);
  endfunction

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readStatus(input string tag);
    regAddr = 2'd0;
    #1;
    checkVal(tag, rdData, expStatus());
  endtask

  task automatic applyCycle(input logic [31:0] evt, input logic doClr, input logic [31:0] clr);
    evtIn = evt;
    if (doClr) begin wrEn = 1'b1; regAddr = 2'd1; wrData = clr; end
    @(negedge clk);
    evtIn = '0; wrEn = 1'b0; regAddr = 2'd0; wrData = '0;
    if (doClr) model = model & ~clr;
    model = (model | (evt & ~TMO_POS)) & EVT_POS;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; regAddr = 2'd0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    readStatus("R1 status");
    regAddr = 2'd2; #1; checkVal("R1 mask", rdData, '0);
    checkVal("R1 irq", {31'b0, irq}, '0);

    // Vector table: R2 set/hold, R3 clear, R4 event wins, R6 ignore, R7 evtIn[2]
    for (int i = 0; i < 8; i++) begin
      applyCycle(VEC_TBL[i][63:32], VEC_TBL[i][64], VEC_TBL[i][31:0]);
      readStatus($sformatf("R2/R3/R4/R6 vec%0d", i));
    end
    @(negedge clk);
    readStatus("R2 hold idle");

    // R11 clear and spare addresses read zero
    applyCycle(32'h0000_0300, 1'b0, '0);
    regAddr = 2'd1; #1; checkVal("R11 clear reads zero", rdData, '0);
    regAddr = 2'd3; #1; checkVal("R11 spare reads zero", rdData, '0);

    // R5 live bits follow input, survive clear
    liveIn = 11'h5A5; #1;
    readStatus("R5 live mirror");
    applyCycle('0, 1'b1, 32'h003F_F800);
    readStatus("R5 clear ignores live");

    // R9 write to status address ignored
    writeReg(2'd0, 32'hFFFF_FFFF);
    readStatus("R9 status write ignored");
    regAddr = 2'd2; #1; checkVal("R9 mask untouched", rdData, '0);

    // R10 mask and irq
    liveIn = '0;
    applyCycle('0, 1'b1, 32'hFFFF_FFFF);
    writeReg(2'd2, 32'h0000_0020);
    maskM = 32'h0000_0020;
    regAddr = 2'd2; #1; checkVal("R10 mask readback", rdData, maskM);
    checkVal("R10 irq low", {31'b0, irq}, 32'd0);
    applyCycle(32'h0000_0020, 1'b0, '0);
    #1; checkVal("R10 irq from event", {31'b0, irq}, 32'd1);
    applyCycle('0, 1'b1, 32'h0000_0020);
    writeReg(2'd2, 32'h0000_0800);
    liveIn = 11'h001; #1;
    checkVal("R10 irq from live", {31'b0, irq}, 32'd1);
    liveIn = '0; #1;
    checkVal("R10 irq drops with live", {31'b0, irq}, 32'd0);

    // R7 timeout at exactly 64 edges
    cmdIssued = 1'b1; @(negedge clk); cmdIssued = 1'b0;
    repeat (63) @(negedge clk);
    readStatus("R7 no timeout at 63");
    @(negedge clk);
    model = model | TMO_POS;
    readStatus("R7 timeout at 64");
    applyCycle('0, 1'b1, TMO_POS);
    readStatus("R3 timeout cleared");

    // R8 response on last edge cancels
    cmdIssued = 1'b1; @(negedge clk); cmdIssued = 1'b0;
    repeat (63) @(negedge clk);
    respSeen = 1'b1; @(negedge clk); respSeen = 1'b0;
    repeat (5) @(negedge clk);
    readStatus("R8 response cancels");

    // R8 second command restarts count
    cmdIssued = 1'b1; @(negedge clk); cmdIssued = 1'b0;
    repeat (39) @(negedge clk);
    cmdIssued = 1'b1; @(negedge clk); cmdIssued = 1'b0;
    repeat (40) @(negedge clk);
    readStatus("R8 restart delays timeout");
    repeat (24) @(negedge clk);
    model = model | TMO_POS;
    readStatus("R8 restarted timeout fires");

    // Randomized stretch against the model (R2 R3 R4 R5 R6)
    lfsr = 32'h1D87_2B41;
    for (int k = 0; k < 60; k++) begin
      logic [31:0] evtR, clrR;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      evtR = lfsr & {lfsr[15:0], lfsr[31:16]};
      clrR = ~lfsr;
      liveIn = lfsr[26:16];
      applyCycle(evtR, lfsr[3], clrR);
      readStatus($sformatf("R2/R3/R4 random %0d", k));
    end

    finishRun();
  end
endmodule